// File: doc/BRIEF.md
# Burst Read Line Cache

This block reads a stored video frame back from external memory, one line per burst, through a simplified AXI4 read address and read data channel. It stays idle until a start pulse arrives from the frame writer. It then issues one read burst per line at consecutive line addresses. From every 32-bit data beat it keeps the luminance byte and writes it into an on-chip circular cache. The cache is as deep as one tile height of lines.

A downstream consumer pulls pixels in frame order by raising a request strobe. Each accepted request advances the cache read pointer. The addressed pixel appears one cycle later, together with a valid flag. A line slot is handed back to the read master only when the consumer has taken every pixel of it. Because of this, bursts are held back while the cache is full of unread lines. Once the last pixel of the frame is consumed, the block returns to idle and waits for the next start pulse.

Top module: `lc_line_cache`

## Requirements
- R1: After reset and between frames, no read burst is requested (`ar_valid_o` low) until `rd_start_i` is seen while idle.
- R2: Each frame issues exactly NUM_LINES bursts. Burst n (counting from 0) has address BASE_ADDR + n·LINE_W·4 and `ar_len_o` = LINE_W−1.
- R3: Once `ar_valid_o` is raised, it and `ar_addr_o` hold unchanged until the cycle in which `ar_ready_i` is high.
- R4: The number of lines requested but not yet fully consumed never exceeds TILE_H. No beat is accepted while the cache holds TILE_H·LINE_W unread pixels.
- R5: The stored pixel is bits [7:0] of the data beat. Bits [31:8] are discarded.
- R6: Pixels leave in frame order, line by line and column by column. Cache slots are reused modulo TILE_H.
- R7: A request accepted in cycle t gives `pix_valid_o` high with the pixel on `pix_o` in cycle t+1. `pix_valid_o` is never high without a request in the previous cycle.
- R8: A request made while no unread pixel is stored is ignored. `pix_valid_o` stays low, and the next accepted request still returns the next pixel in order.
- R9: `r_ready_o` is high for the whole of an active frame and low when idle. After the last pixel the block goes idle, a new start restarts at burst 0, and `rd_start_i` during an active frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_start_i | input | 1 | Frame read trigger from the writer |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_addr_o | output | ADDR_W | Burst start byte address |
| ar_len_o | output | 8 | Burst length minus one |
| r_valid_i | input | 1 | Read data valid |
| r_ready_o | output | 1 | Read data ready |
| r_data_i | input | DATA_W | Read data beat; luma in bits [7:0] |
| pix_req_i | input | 1 | Consumer pixel request strobe |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_o | output | 8 | Cached luminance pixel |

## Verification
The properties assume that the memory returns data beats only for bursts it has already accepted, in request order, with LINE_W beats per burst. They also assume that `ar_ready_i` and `r_valid_i` are free to stall for any number of cycles. The bench memory model keeps to this by queuing the accepted addresses and streaming each line in full before the next. It is run once with throttled address and data channels and an eager consumer, and once with a fast memory and a slow consumer, so that both the empty-cache and the full-cache limits are reached.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef logic [7:0] pix_t;

  // luma sits in the low byte of each beat
  function automatic pix_t luma_of(input logic [31:0] beat);
    return beat[7:0];
  endfunction
endpackage

// File: rtl/lc_slot_ptr.sv
module lc_slot_ptr #(
  parameter int unsigned LINE_W = 64,
  parameter int unsigned TILE_H = 8,
  localparam int unsigned CAP    = LINE_W * TILE_H,
  localparam int unsigned AW     = $clog2(CAP),
  localparam int unsigned COL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1,
  localparam int unsigned SLOT_W = (TILE_H > 1) ? $clog2(TILE_H) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o
);
  logic [COL_W-1:0]  col_q;
  logic [SLOT_W-1:0] slot_q;
  logic              col_end, slot_end;

  assign col_end  = (col_q == COL_W'(LINE_W - 1));
  assign slot_end = (slot_q == SLOT_W'(TILE_H - 1));
  assign wrap_o   = adv_i && col_end;
  assign addr_o   = AW'(slot_q) * AW'(LINE_W) + AW'(col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      slot_q <= '0;
    end else if (clr_i) begin
      col_q  <= '0;
      slot_q <= '0;
    end else if (adv_i) begin
      if (col_end) begin
        col_q  <= '0;
        slot_q <= slot_end ? '0 : slot_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lc_line_ram.sv
module lc_line_ram #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  lc_pkg::pix_t  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output lc_pkg::pix_t  rdata_o
);
  lc_pkg::pix_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lc_ar_issue.sv
module lc_ar_issue #(
  parameter int unsigned LINE_W    = 64,
  parameter int unsigned TILE_H    = 8,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int unsigned LINE_BYTES = LINE_W * 4,
  localparam int unsigned CNT_W = $clog2(NUM_LINES + 1),
  localparam int unsigned OUT_W = $clog2(TILE_H + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              active_i,
  input  logic              line_done_i,
  input  logic              ar_ready_i,
  output logic              ar_valid_o,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [OUT_W-1:0]  lines_out_o
);
  logic [CNT_W-1:0] issued_q;
  logic             can_issue, ar_fire;

  assign ar_len_o  = 8'(LINE_W - 1);
  assign ar_fire   = ar_valid_o && ar_ready_i;
  // a slot must be free before its burst is requested
  assign can_issue = active_i && !ar_valid_o
                   && (issued_q < CNT_W'(NUM_LINES))
                   && (lines_out_o < OUT_W'(TILE_H));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q    <= '0;
      lines_out_o <= '0;
      ar_valid_o  <= 1'b0;
      ar_addr_o   <= '0;
    end else if (clr_i) begin
      issued_q    <= '0;
      lines_out_o <= '0;
      ar_valid_o  <= 1'b0;
    end else begin
      if (can_issue) begin
        ar_valid_o <= 1'b1;
        ar_addr_o  <= BASE_ADDR + ADDR_W'(issued_q) * ADDR_W'(LINE_BYTES);
      end else if (ar_fire) begin
        ar_valid_o <= 1'b0;
      end
      if (ar_fire) issued_q <= issued_q + 1'b1;
      lines_out_o <= lines_out_o + OUT_W'(ar_fire) - OUT_W'(line_done_i);
    end
  end
endmodule

// File: rtl/lc_line_cache.sv
module lc_line_cache #(
  parameter int unsigned LINE_W    = 64,
  parameter int unsigned TILE_H    = 8,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000,
  localparam int unsigned CAP    = LINE_W * TILE_H,
  localparam int unsigned AW     = $clog2(CAP),
  localparam int unsigned FILL_W = $clog2(CAP + 1),
  localparam int unsigned CNT_W  = $clog2(NUM_LINES + 1),
  localparam int unsigned OUT_W  = $clog2(TILE_H + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic              pix_req_i,
  output logic              pix_valid_o,
  output logic [7:0]        pix_o
);
  logic              active_q, start, beat, req_ok, line_done, frame_done;
  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  consumed_q;
  logic [OUT_W-1:0]  lines_out;
  logic [AW-1:0]     waddr, raddr;
  logic              wr_wrap;

  assign start      = rd_start_i && !active_q;
  assign r_ready_o  = active_q;
  assign beat       = r_valid_i && r_ready_o;
  assign req_ok     = pix_req_i && (fill_q != '0);
  assign frame_done = line_done && (consumed_q == CNT_W'(NUM_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      fill_q      <= '0;
      consumed_q  <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      pix_valid_o <= req_ok;
      if (start) begin
        active_q   <= 1'b1;
        fill_q     <= '0;
        consumed_q <= '0;
      end else begin
        if (frame_done) active_q <= 1'b0;
        fill_q <= fill_q + FILL_W'(beat) - FILL_W'(req_ok);
        if (line_done) consumed_q <= consumed_q + 1'b1;
      end
    end
  end

  lc_ar_issue #(
    .LINE_W(LINE_W), .TILE_H(TILE_H), .NUM_LINES(NUM_LINES),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) ar_i (
    .clk_i, .rst_ni,
    .clr_i       (start),
    .active_i    (active_q),
    .line_done_i (line_done),
    .ar_ready_i,
    .ar_valid_o,
    .ar_addr_o,
    .ar_len_o,
    .lines_out_o (lines_out)
  );

  lc_slot_ptr #(.LINE_W(LINE_W), .TILE_H(TILE_H)) wr_ptr_i (
    .clk_i, .rst_ni,
    .clr_i  (start),
    .adv_i  (beat),
    .addr_o (waddr),
    .wrap_o (wr_wrap)
  );

  lc_slot_ptr #(.LINE_W(LINE_W), .TILE_H(TILE_H)) rd_ptr_i (
    .clk_i, .rst_ni,
    .clr_i  (start),
    .adv_i  (req_ok),
    .addr_o (raddr),
    .wrap_o (line_done)
  );

  lc_line_ram #(.DEPTH(CAP)) ram_i (
    .clk_i,
    .we_i    (beat),
    .waddr_i (waddr),
    .wdata_i (lc_pkg::luma_of(32'(r_data_i))),
    .re_i    (req_ok),
    .raddr_i (raddr),
    .rdata_o (pix_o)
  );

  // write-side line boundary is implied by the beat count
  logic unused_wrap;
  assign unused_wrap = wr_wrap;
endmodule

// File: rtl/lc_line_cache_chk.sv
module lc_line_cache_chk #(
  parameter int unsigned TILE_H = 8,
  parameter int unsigned CAP    = 512,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned FILL_W = $clog2(CAP + 1),
  localparam int unsigned OUT_W  = $clog2(TILE_H + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_q,
  input logic              ar_valid_o,
  input logic              ar_ready_i,
  input logic [ADDR_W-1:0] ar_addr_o,
  input logic              r_valid_i,
  input logic              r_ready_o,
  input logic              pix_req_i,
  input logic              pix_valid_o,
  input logic [FILL_W-1:0] fill_q,
  input logic [OUT_W-1:0]  lines_out
);
  // R1
  idle_no_ar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !ar_valid_o);
  // R3
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o));
  // R4
  slot_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> lines_out < OUT_W'(TILE_H));
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_i && r_ready_o |-> fill_q < FILL_W'(CAP));
  // R7
  pix_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(pix_req_i));
  // R8
  empty_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_i && fill_q == '0 |=> !pix_valid_o);
endmodule

bind lc_line_cache lc_line_cache_chk #(
  .TILE_H(TILE_H), .CAP(CAP), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i, .rst_ni, .active_q, .ar_valid_o, .ar_ready_i, .ar_addr_o,
  .r_valid_i, .r_ready_o, .pix_req_i, .pix_valid_o, .fill_q, .lines_out
);

// File: tb/lc_line_cache_tb_top.sv
module lc_line_cache_tb_top;
  localparam int LW = 8, TH = 4, NL = 12, TOTAL = LW * NL;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 0, rst_ni = 0;
  logic rd_start_i = 0, ar_ready_i = 0, r_valid_i = 0, pix_req_i = 0;
  logic [31:0] r_data_i = '0;
  logic ar_valid_o, r_ready_o, pix_valid_o;
  logic [31:0] ar_addr_o;
  logic [7:0] ar_len_o, pix_o;

  always #2.5 clk = ~clk;

  lc_line_cache #(.LINE_W(LW), .TILE_H(TH), .NUM_LINES(NL), .BASE_ADDR(BASE)) dut_i (
    .clk_i(clk), .rst_ni, .rd_start_i, .ar_valid_o, .ar_ready_i, .ar_addr_o,
    .ar_len_o, .r_valid_i, .r_ready_o, .r_data_i, .pix_req_i, .pix_valid_o, .pix_o);

  int n_run = 0, n_fail = 0, cyc = 0;
  int issued_b, served_b, beat_b, reads_b, fill_b, exp_idx;
  bit exp_v = 0, prev_pend = 0;
  logic [31:0] prev_addr;
  int bw [NL];

  function automatic logic [31:0] mem_word(input int w);
    logic [31:0] v = 32'(w);
    return {~v[23:0], 8'((w * 29 + 11) & 255)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 1: fast memory, slow consumer; mode 0: throttled memory, eager consumer
  task automatic step(input bit mode, input bit want, input bit start);
    bit acc_r, acc_q;
    chk(pix_valid_o === exp_v, "R7/R8 pix_valid", pix_valid_o, exp_v);
    if (exp_v) chk(pix_o === mem_word(BASE / 4 + exp_idx)[7:0], "R5/R6 pixel",
                   pix_o, mem_word(BASE / 4 + exp_idx)[7:0]);
    if (prev_pend) chk(ar_valid_o && ar_addr_o == prev_addr, "R3 ar hold", ar_addr_o, prev_addr);
    rd_start_i = start;
    ar_ready_i = mode ? 1'b1 : cyc[0];
    prev_pend  = ar_valid_o && !ar_ready_i;
    prev_addr  = ar_addr_o;
    // data channel (bursts known before this edge only)
    r_valid_i = (served_b < issued_b) && (mode || (cyc % 3 != 0));
    r_data_i  = r_valid_i ? mem_word(bw[served_b] + beat_b) : '0;
    if (r_valid_i) chk(r_ready_o === 1'b1, "R9 r_ready", r_ready_o, 1);
    acc_r = r_valid_i && r_ready_o;
    if (acc_r) begin
      beat_b++;
      if (beat_b == LW) begin beat_b = 0; served_b++; end
    end
    if (ar_valid_o && ar_ready_i) begin
      chk(ar_addr_o == BASE + 32'(issued_b * LW * 4), "R2 ar addr", ar_addr_o, BASE + issued_b * LW * 4);
      chk(ar_len_o == 8'(LW - 1), "R2 ar len", ar_len_o, LW - 1);
      chk(issued_b < NL, "R2 burst count", issued_b, NL - 1);
      chk(issued_b - reads_b / LW < TH, "R4 slots", issued_b - reads_b / LW, TH - 1);
      if (issued_b < NL) bw[issued_b] = int'(ar_addr_o / 4);
      issued_b++;
    end
    pix_req_i = want;
    acc_q = want && fill_b > 0;
    exp_v = acc_q;
    exp_idx = reads_b;
    if (acc_q) reads_b++;
    fill_b += int'(acc_r) - int'(acc_q);
    cyc++;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit mode);
    int n = 0;
    issued_b = 0; served_b = 0; beat_b = 0; reads_b = 0; fill_b = 0;
    step(mode, 0, 1);
    while (reads_b < TOTAL && n < 5000) begin
      step(mode, mode ? (cyc % 4 == 0) : (cyc % 5 != 0), reads_b == 20); // R9 mid-frame start
      n++;
    end
    if (n >= 5000) chk(0, "watchdog", reads_b, TOTAL);
    for (int i = 0; i < 6; i++) begin
      step(mode, i == 2, 0); // R8 request after frame end
      chk(!ar_valid_o, "R2 no extra burst", ar_valid_o, 0);
      chk(!r_ready_o, "R9 idle r_ready", r_ready_o, 0);
    end
    chk(issued_b == NL, "R2 bursts per frame", issued_b, NL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!ar_valid_o && !pix_valid_o && !r_ready_o, "reset state", ar_valid_o, 0);
    issued_b = 0; served_b = 0; beat_b = 0; reads_b = 0; fill_b = 0;
    for (int i = 0; i < 8; i++) begin
      step(0, i == 3, 0); // R8 request before any data
      chk(!ar_valid_o, "R1 idle", ar_valid_o, 0);
    end
    run_frame(0);
    run_frame(1); // R9 restart at burst 0
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule